// File: doc/BRIEF.md
# Shared-Bus I2C Clock and Arbitration Front End

This block sits between an I2C master's byte engine and the two open-drain bus wires. The wires may be shared with other masters. It never drives a line high. It either pulls a line low or releases it, and it reads both wires back through a two-flop synchroniser. The block makes its own SCL low and high periods. It lines those periods up with the wired-AND level seen on the wire, so the longest low request and the earliest pull-down by any device set the real clock. It waits as long as needed while a slave stretches the clock. It watches for START and STOP to know when the bus is busy or free.

The byte engine sends it one bus action at a time on a valid/ready command channel. The four actions are START (also used for a repeated START), STOP, write one bit, and read one bit. Each action that completes returns a result on a valid/ready response channel. While a response is waiting to be taken, the block keeps SCL low, so back-pressure from the byte engine simply stretches the bus clock. On a written bit, the block compares the level it sends with the level it senses while SCL is high. If it releases SDA but senses it low, it gives up the bus at once and reports lost arbitration.

Top module: `mm_i2c_front`

## Requirements
- R1: While reset is held, and just after it, the block releases both lines, reports the bus as not busy, holds cmd_ready high and holds rsp_valid low.
- R2: A START issued while the block does not own the bus waits until the bus is idle. It then pulls SDA low while SCL is high, and after that pulls SCL low and returns a response. A repeated START from an owned bus first releases SDA during the low phase.
- R3: For each clocked action the block holds SCL low for at least T_LOW cycles. It then waits, with no time limit, for as long as any other device keeps SCL low.
- R4: The high-period count starts only once SCL is sensed high. It ends after T_HIGH cycles, or earlier when SCL is sensed low. In both cases the block then pulls SCL low and completes the action.
- R5: For write and read bit actions, the block's SDA drive changes only while SCL is held low. SDA stays stable throughout the high phase.
- R6: On a write bit with value 1, sensing SDA low during the high phase raises arb_lost for exactly one cycle. In that same cycle both lines are released. Writing 0, or writing 1 while others also send 1, does not lose arbitration.
- R7: After arbitration is lost, the block drives neither line and holds cmd_ready low until the bus is idle again. It returns no response for the lost action.
- R8: A read bit releases SDA. It returns in rsp_bit the SDA level sensed at the start of the high phase. A write bit returns the sensed level the same way.
- R9: STOP pulls SDA low during the low phase, releases SCL, and after T_HIGH sensed-high cycles releases SDA. This leaves both lines released and the block no longer owning the bus.
- R10: bus_busy rises after a START is seen on the wires. After a STOP is seen, it stays high for T_BUF more cycles of bus-free time before it falls. It stays high if a new START comes first.
- R11: cmd_op codes are 0 = START, 1 = STOP, 2 = write bit, 3 = read bit. A command is taken on a cycle where cmd_valid and cmd_ready are both high. rsp_valid stays high with a stable rsp_bit until rsp_ready is high, and SCL stays held low while an owned-bus response waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level read from the wire |
| sda_in | input | 1 | Raw SDA level read from the wire |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cmd_valid | input | 1 | Command offered by the byte engine |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | Command code (see R11) |
| cmd_bit | input | 1 | Bit value for a write bit |
| rsp_valid | output | 1 | Action finished, result held |
| rsp_ready | input | 1 | Byte engine takes the result |
| rsp_bit | output | 1 | SDA level sampled in the high phase |
| bus_busy | output | 1 | Bus is between START and bus-free end |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |

## Verification
The in-RTL properties assume that the byte engine sends write and read bits only after a START that it owns. They also assume that other devices change SDA only while SCL is low, apart from their own START and STOP. The bench's model of other masters and slaves keeps to this. It pulls SDA low before a bit begins, while the block still holds SCL low, and lets it go only after the response arrives. Clock stretching and the early cutting of a high phase are applied only through the shared SCL wire. External START and STOP conditions are made only while SCL is released high.

// File: rtl/mm_i2c_pkg.sv
package mm_i2c_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_LOWCNT, S_RISE, S_HIGHCNT, S_RESP, S_LOST
  } eng_state_e;
endpackage

// File: rtl/mm_sync2.sv
module mm_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  // released open-drain wires read high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mm_bus_watch.sv
module mm_bus_watch #(
  parameter int T_BUF = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);
  localparam int BW = $clog2(T_BUF + 1);
  localparam logic [BW-1:0] BUF_LAST = BW'(T_BUF - 1);

  logic          scl_q, sda_q, pend;
  logic [BW-1:0] free_cnt;
  logic          start_det, stop_det;

  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      busy     <= 1'b0;
      pend     <= 1'b0;
      free_cnt <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_det) begin
        busy <= 1'b1;
        pend <= 1'b0;
      end else if (stop_det) begin
        pend     <= 1'b1;
        free_cnt <= '0;
      end else if (pend) begin
        if (free_cnt == BUF_LAST) begin
          pend <= 1'b0;
          busy <= 1'b0;
        end else begin
          free_cnt <= free_cnt + 1'b1;
        end
      end
    end
  end

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_det));
  // R10
  free_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && busy) |=> busy);
endmodule

// File: rtl/mm_bit_engine.sv
module mm_bit_engine
  import mm_i2c_pkg::*;
#(
  parameter int T_LOW  = 63,
  parameter int T_HIGH = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       busy,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       rsp_bit,
  output logic       arb_lost,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(T_LOW - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(T_HIGH - 1);

  eng_state_e    state;
  bus_op_e       op_q;
  logic          sda_rel, owned, phase, rx_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_START;
      sda_rel  <= 1'b1;
      owned    <= 1'b0;
      phase    <= 1'b0;
      rx_q     <= 1'b1;
      cnt      <= '0;
      arb_lost <= 1'b0;
    end else begin
      arb_lost <= 1'b0;
      case (state)
        S_IDLE, S_HOLD: begin
          if (cmd_valid) begin
            op_q  <= bus_op_e'(cmd_op);
            cnt   <= '0;
            phase <= 1'b0;
            state <= S_LOWCNT;
            case (bus_op_e'(cmd_op))
              OP_STOP:  sda_rel <= 1'b0;
              OP_WRITE: sda_rel <= cmd_bit;
              default:  sda_rel <= 1'b1;
            endcase
          end
        end
        S_LOWCNT: begin
          if (!owned && busy) cnt <= '0;
          else if (cnt == LOW_LAST) begin
            cnt   <= '0;
            state <= S_RISE;
          end else cnt <= cnt + 1'b1;
        end
        S_RISE: begin
          if (scl_s) begin
            cnt   <= '0;
            state <= S_HIGHCNT;
          end
        end
        S_HIGHCNT: begin
          if (op_q == OP_WRITE && sda_rel && !sda_s) begin
            arb_lost <= 1'b1;
            sda_rel  <= 1'b1;
            owned    <= 1'b0;
            state    <= S_LOST;
          end else if (!scl_s) begin
            if (op_q == OP_START) owned <= 1'b1;
            state <= S_RESP;
          end else begin
            if (cnt == '0) rx_q <= sda_s;
            if (cnt == HIGH_LAST) begin
              cnt <= '0;
              case (op_q)
                OP_START: begin
                  if (!phase) begin
                    phase   <= 1'b1;
                    sda_rel <= 1'b0;
                  end else begin
                    owned <= 1'b1;
                    state <= S_RESP;
                  end
                end
                OP_STOP: begin
                  sda_rel <= 1'b1;
                  owned   <= 1'b0;
                  state   <= S_RESP;
                end
                default: state <= S_RESP;
              endcase
            end else cnt <= cnt + 1'b1;
          end
        end
        S_RESP: if (rsp_ready) state <= owned ? S_HOLD : S_IDLE;
        S_LOST: if (!busy) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign scl_low   = owned && (state == S_HOLD || state == S_LOWCNT || state == S_RESP);
  assign sda_low   = !sda_rel && state != S_IDLE && state != S_LOST;
  assign cmd_ready = (state == S_IDLE) || (state == S_HOLD);
  assign rsp_valid = (state == S_RESP);
  assign rsp_bit   = rx_q;

  // R4
  high_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGHCNT && $past(state) == S_RISE) |-> $past(scl_s));
  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGHCNT && $past(state) == S_HIGHCNT &&
     (op_q == OP_WRITE || op_q == OP_READ)) |-> $stable(sda_low));
  // R6
  arb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> ($past(op_q) == OP_WRITE && !$past(sda_s)));
  // R6
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bit)));
endmodule

// File: rtl/mm_i2c_front.sv
module mm_i2c_front #(
  parameter int T_LOW  = 63,
  parameter int T_HIGH = 62,
  parameter int T_BUF  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       rsp_bit,
  output logic       bus_busy,
  output logic       arb_lost
);
  logic [1:0] raw_pair, sync_pair;

  assign raw_pair = {scl_in, sda_in};

  mm_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pair), .q(sync_pair)
  );

  mm_bus_watch #(.T_BUF(T_BUF)) u_watch (
    .clk(clk), .rst_n(rst_n),
    .scl_s(sync_pair[1]), .sda_s(sync_pair[0]), .busy(bus_busy)
  );

  mm_bit_engine #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .scl_s(sync_pair[1]), .sda_s(sync_pair[0]), .busy(bus_busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bit(rsp_bit),
    .arb_lost(arb_lost), .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  // R1
  release_on_reset_chk: assert property (@(posedge clk)
    !rst_n |-> (!scl_drive_low && !sda_drive_low && !bus_busy));
endmodule

// File: tb/mm_i2c_front_tb.sv
module mm_i2c_front_tb;
  localparam int PERIOD = 10;
  localparam int TL = 8;
  localparam int TH = 6;
  localparam int TB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0, rsp_ready = 1'b1;
  logic [1:0] cmd_op = 2'd0;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  logic scl_dl, sda_dl, cmd_ready, rsp_valid, rsp_bit, bus_busy, arb_lost;
  logic scl_bus, sda_bus;

  assign scl_bus = ~(scl_dl | tb_scl_low);
  assign sda_bus = ~(sda_dl | tb_sda_low);

  always #(PERIOD/2) clk = ~clk;

  mm_i2c_front #(.T_LOW(TL), .T_HIGH(TH), .T_BUF(TB)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_bit(rsp_bit),
    .bus_busy(bus_busy), .arb_lost(arb_lost)
  );

  int checks = 0, fails = 0;
  int cyc = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  int sda_hi_evt = 0, stop_cyc = 0, free_cyc = 0, lost_cnt = 0, lost_bad = 0;
  logic p_scl = 1'b1, p_sda = 1'b1, p_busy = 1'b0;

  // bus observer, sampled away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (scl_bus) begin
      hi_run <= hi_run + 1;
      if (!p_scl) begin last_lo <= lo_run; lo_run <= 0; end
    end else begin
      lo_run <= lo_run + 1;
      if (p_scl) begin last_hi <= hi_run; hi_run <= 0; end
    end
    if (scl_bus && p_scl && sda_bus != p_sda) sda_hi_evt <= sda_hi_evt + 1;
    if (scl_bus && p_scl && sda_bus && !p_sda) stop_cyc <= cyc;
    if (p_busy && !bus_busy) free_cyc <= cyc;
    if (arb_lost) begin
      lost_cnt <= lost_cnt + 1;
      if (scl_dl || sda_dl) lost_bad <= lost_bad + 1;
    end
    p_scl <= scl_bus; p_sda <= sda_bus; p_busy <= bus_busy;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic b,
                         output logic rb, output logic lost, output logic ok);
    int t;
    @(negedge clk);
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0;
    while (!rsp_valid && !arb_lost && t < 3000) begin
      @(negedge clk);
      t++;
    end
    rb = rsp_bit; lost = arb_lost; ok = (t < 3000);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {op[1:0], bit, other-device SDA low, check rsp_bit, expected bit, expected loss}
  localparam int NV = 9;
  localparam logic [6:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 START from idle
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 R8 write 1 unopposed
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 write 0
    {2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R8 read, slave sends 0
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 read, slave sends 1
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 write 0 with other 0
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 repeated START
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 write 1 after restart
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R9 STOP
  };

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic rb, lost, ok, flag;
    int evt0, lc0;
    wait_n(4);
    // R1 reset state
    chk(!scl_dl && !sda_dl, "R1 lines released in reset", scl_dl + sda_dl, 0);
    rst_n = 1'b1;
    wait_n(2);
    chk(!bus_busy, "R1 not busy", bus_busy, 0);
    chk(cmd_ready && !rsp_valid, "R1 ready/no rsp", {cmd_ready, rsp_valid}, 2);

    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      v = VEC[i];
      tb_sda_low = v[3];
      evt0 = sda_hi_evt;
      run_cmd(v[6:5], v[4], rb, lost, ok);
      tb_sda_low = 1'b0;
      chk(ok, "R11 response arrives", ok, 1);
      chk(lost == v[0], "R6 arbitration outcome", lost, v[0]);
      if (v[2]) chk(rb == v[1], "R8 rsp_bit", rb, v[1]);
      wait_n(2);
      if (v[6]) begin
        chk(sda_hi_evt == evt0, "R5 SDA stable in high", sda_hi_evt - evt0, 0);
        chk(last_lo >= TL, "R3 low length", last_lo, TL);
      end else begin
        chk(sda_hi_evt == evt0 + 1, "R2 R9 one START/STOP edge", sda_hi_evt - evt0, 1);
      end
      if (v[6:5] == 2'd0)
        chk(bus_busy && !scl_bus && !sda_bus, "R2 owned after START", {bus_busy, scl_bus, sda_bus}, 4);
      if (v[6:5] == 2'd1) begin
        chk(bus_busy && scl_bus && sda_bus && !scl_dl, "R9 R10 released, still busy",
            {bus_busy, scl_bus, sda_bus, scl_dl}, 14);
        while (bus_busy) @(negedge clk);
        wait_n(1);
        chk(free_cyc - stop_cyc >= TB && free_cyc - stop_cyc <= TB + 6,
            "R10 bus-free time", free_cyc - stop_cyc, TB);
      end
    end

    // R3 slave stretch, R4 high count after sensed high
    run_cmd(2'd0, 1'b0, rb, lost, ok);
    fork
      run_cmd(2'd3, 1'b0, rb, lost, ok);
      begin tb_scl_low = 1'b1; wait_n(40); tb_scl_low = 1'b0; end
    join
    wait_n(2);
    chk(ok && last_lo >= 40, "R3 stretched low waited", last_lo, 40);
    chk(last_hi >= TH && last_hi <= TH + 4, "R4 high length", last_hi, TH);

    // R4 high phase cut short by another device
    fork
      run_cmd(2'd3, 1'b0, rb, lost, ok);
      begin
        while (!scl_bus) @(negedge clk);
        wait_n(1);
        tb_scl_low = 1'b1;
        while (!rsp_valid) @(negedge clk);
        wait_n(1);
        tb_scl_low = 1'b0;
      end
    join
    wait_n(2);
    chk(ok && last_hi <= 3, "R4 early fall ends high", last_hi, 2);
    chk(scl_dl, "R4 block holds SCL after cut", scl_dl, 1);

    // R11 response back-pressure holds SCL low
    rsp_ready = 1'b0;
    run_cmd(2'd2, 1'b0, rb, lost, ok);
    flag = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!rsp_valid || scl_bus || rsp_bit) flag = 1'b0;
    end
    chk(ok && flag, "R11 rsp held, SCL low", flag, 1);
    rsp_ready = 1'b1;
    wait_n(2);
    chk(!rsp_valid, "R11 rsp taken", rsp_valid, 0);
    run_cmd(2'd1, 1'b0, rb, lost, ok);

    // R2 START waits while another master owns the bus
    while (bus_busy) @(negedge clk);
    wait_n(2);
    tb_sda_low = 1'b1;
    wait_n(5);
    chk(bus_busy, "R10 external START seen", bus_busy, 1);
    flag = 1'b1;
    fork
      run_cmd(2'd0, 1'b0, rb, lost, ok);
      begin
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          if (scl_dl || sda_dl) flag = 1'b0;
        end
        tb_sda_low = 1'b0;
      end
    join
    chk(flag, "R2 no drive while busy", flag, 1);
    chk(ok && scl_dl && sda_dl, "R2 START after idle", {scl_dl, sda_dl}, 3);

    // R6 R7 arbitration loss
    tb_sda_low = 1'b1;
    lc0 = lost_cnt;
    run_cmd(2'd2, 1'b1, rb, lost, ok);
    wait_n(3);
    chk(lost, "R6 lost on write 1 vs 0", lost, 1);
    chk(lost_cnt == lc0 + 1, "R6 single-cycle pulse", lost_cnt - lc0, 1);
    chk(lost_bad == 0, "R6 lines released with pulse", lost_bad, 0);
    chk(!cmd_ready && !rsp_valid, "R7 no ready, no rsp", {cmd_ready, rsp_valid}, 0);
    flag = 1'b1;
    tb_scl_low = 1'b1;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (scl_dl || sda_dl) flag = 1'b0; end
    tb_scl_low = 1'b0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (scl_dl || sda_dl) flag = 1'b0; end
    tb_sda_low = 1'b0;
    wait_n(3);
    chk(!cmd_ready, "R7 still locked before bus free", cmd_ready, 0);
    for (int k = 0; k < TB + 10; k++) begin @(negedge clk); if (scl_dl || sda_dl) flag = 1'b0; end
    chk(flag, "R7 no drive after loss", flag, 1);
    chk(cmd_ready && !bus_busy, "R7 ready once idle", {cmd_ready, bus_busy}, 2);

    finish_run();
  end
endmodule